// File: doc/BRIEF.md
# Packed-Nibble Voice Record and Playback Sequencer

This controller moves 4-bit compressed speech codes between an external codec and an asynchronous byte-wide SRAM. It sits in standby until a record or play button is pressed. In record mode it collects one code from the encoder on each sample tick and pairs consecutive codes into one byte, which it writes with a five-cycle strobe sequence. In playback mode it fetches one byte every second tick with a three-cycle read sequence and hands the two nibbles to the decoder on consecutive ticks. On each playback tick it copies the decoder's 8-bit sample into the PWM duty register.

Both modes start at address 0 and end on their own after a fixed number of bytes. At that point the sequencer returns to standby and clears the PWM duty. Every SRAM sequence must finish within one tick period. A tick that arrives while a sequence is still running sets a sticky error flag, and only reset clears that flag.

States: `ST_IDLE` (standby), `ST_REC_WAIT`, `ST_WR_ADDR`, `ST_WR_OEH`, `ST_WR_WEL`, `ST_WR_DATA`, `ST_WR_REL`, `ST_PLAY_WAIT`, `ST_RD_ADDR`, `ST_RD_OEL`, `ST_RD_CAP`.

Transitions:
- `ST_IDLE` goes to `ST_REC_WAIT` when the record button is pressed. If only the play button is pressed, it goes to `ST_PLAY_WAIT`.
- `ST_REC_WAIT` goes to `ST_WR_ADDR` on a tick that completes a pair of codes.
- The write steps follow each other in order. After `ST_WR_REL` the machine returns to `ST_REC_WAIT`, or to `ST_IDLE` after the final byte.
- `ST_PLAY_WAIT` goes to `ST_RD_ADDR` on an even tick. On an odd tick it stays in `ST_PLAY_WAIT`, or goes to `ST_IDLE` if the byte was the final one.
- The read steps run `ST_RD_ADDR`, `ST_RD_OEL`, `ST_RD_CAP`, then back to `ST_PLAY_WAIT`.

Top module: `voice_seq`

## Requirements
- R1: In standby, `rec_btn` enters record mode and `play_btn` enters playback mode. Record wins when both are high. `mode` reads 0 for standby, 1 for record and 2 for playback, and `busy` is high whenever `mode` is not 0.
- R2: While `busy` is high, both buttons have no effect and `mode` does not change until the run ends.
- R3: In record mode, the code present on an odd-numbered tick of the run (1st, 3rd, ...) becomes bits 7:4 of a byte. The code on the next tick becomes bits 3:0. A byte is written only after the second of the pair.
- R4: A byte write takes one cycle per step: address presented, OE held high, WE low, data driven with WE low, then WE high with data still driven. `sram_dq_oe` is high only in the last two steps.
- R5: In playback, a tick at an even count starts a read: address first, `sram_oe_n` low on the next cycle, data captured at the end of the third cycle. The high nibble appears on `dec_code` with a one-cycle `dec_valid` when the capture completes. The low nibble follows, with another `dec_valid` pulse, in the cycle after the next tick.
- R6: The SRAM address is 0 on entry to either mode and advances by one after each byte.
- R7: After `LEN_BYTES` bytes the block returns to standby and `pwm_duty` reads 0.
- R8: In playback, every tick loads `dec_sample` into `pwm_duty`, except the final tick, which loads 0. Entering either mode clears `pwm_duty`.
- R9: A tick that arrives during a read or write step sets `err`. `err` stays set until reset, and reset clears it.
- R10: `sram_we_n` and `sram_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_btn | input | 1 | Record request |
| play_btn | input | 1 | Playback request |
| tick | input | 1 | One-cycle sample strobe |
| enc_code | input | CODE_W | Code from the encoder |
| sram_din | input | 2*CODE_W | Data read from the SRAM |
| dec_sample | input | PWM_W | Sample from the decoder |
| sram_addr | output | ADDR_W | SRAM address |
| sram_dout | output | 2*CODE_W | Data to the SRAM |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| dec_code | output | CODE_W | Code to the decoder |
| dec_valid | output | 1 | dec_code valid pulse |
| pwm_duty | output | PWM_W | PWM duty value |
| mode | output | 2 | 0 standby, 1 record, 2 playback |
| busy | output | 1 | Not in standby |
| err | output | 1 | Sticky late-tick fault |

## Verification
The bench traces a complete write and a complete read cycle by cycle. A design that asserted WE one step early, dropped the data drive before WE rose, or captured read data before OE was low would show a mismatched strobe or nibble. It records a short run, inspects the bytes in a bench memory model, and then plays them back. Swapped nibbles, a missed address increment or a wrong stop length would show up as wrong bytes, wrong decoder codes or a run that ends late. Button presses during a run, a simultaneous press of both buttons, and a tick injected mid-write check that the mode holds, that record wins, and that the fault flag sticks until reset.

// File: rtl/vs_pkg.sv
package vs_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_REC  = 2'd1,
        MODE_PLAY = 2'd2
    } mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REC_WAIT,
        ST_WR_ADDR,
        ST_WR_OEH,
        ST_WR_WEL,
        ST_WR_DATA,
        ST_WR_REL,
        ST_PLAY_WAIT,
        ST_RD_ADDR,
        ST_RD_OEL,
        ST_RD_CAP
    } state_e;
endpackage

// File: rtl/vs_addr_ctr.sv
module vs_addr_ctr #(
    parameter int ADDR_W    = 15,
    parameter int LEN_BYTES = 32000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(LEN_BYTES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr <= '0;
        end else if (inc) begin
            addr <= addr + 1'b1;
        end
    end

    assign last = (addr == LAST_ADDR);
endmodule

// File: rtl/vs_nibble_buf.sv
module vs_nibble_buf #(
    parameter int CODE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_hi,
    input  logic                load_lo,
    input  logic                load_byte,
    input  logic [CODE_W-1:0]   code_in,
    input  logic [2*CODE_W-1:0] byte_in,
    output logic [2*CODE_W-1:0] byte_q
);
    localparam int DATA_W = 2 * CODE_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (load_byte) begin
            byte_q <= byte_in;
        end else if (load_hi) begin
            byte_q[DATA_W-1 -: CODE_W] <= code_in;
        end else if (load_lo) begin
            byte_q[CODE_W-1:0] <= code_in;
        end
    end
endmodule

// File: rtl/voice_seq.sv
module voice_seq
    import vs_pkg::*;
#(
    parameter int CODE_W    = 4,
    parameter int ADDR_W    = 15,
    parameter int LEN_BYTES = 32000,
    parameter int PWM_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rec_btn,
    input  logic                play_btn,
    input  logic                tick,
    input  logic [CODE_W-1:0]   enc_code,
    input  logic [2*CODE_W-1:0] sram_din,
    input  logic [PWM_W-1:0]    dec_sample,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic [2*CODE_W-1:0] sram_dout,
    output logic                sram_dq_oe,
    output logic                sram_we_n,
    output logic                sram_oe_n,
    output logic [CODE_W-1:0]   dec_code,
    output logic                dec_valid,
    output logic [PWM_W-1:0]    pwm_duty,
    output logic [1:0]          mode,
    output logic                busy,
    output logic                err
);
    localparam int DATA_W = 2 * CODE_W;

    state_e state, state_nx;
    logic   phase;
    logic   last;
    logic   enter;
    logic   seq_run;
    logic   ctr_inc;
    logic   play_lo_tick;
    logic [DATA_W-1:0] byte_q;

    assign enter        = (state == ST_IDLE) && (rec_btn || play_btn);
    assign play_lo_tick = (state == ST_PLAY_WAIT) && tick && phase;
    assign ctr_inc      = (state == ST_WR_REL) || play_lo_tick;

    vs_addr_ctr #(.ADDR_W(ADDR_W), .LEN_BYTES(LEN_BYTES)) i_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (enter),
        .inc  (ctr_inc),
        .addr (sram_addr),
        .last (last)
    );

    vs_nibble_buf #(.CODE_W(CODE_W)) i_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_hi  ((state == ST_REC_WAIT) && tick && !phase),
        .load_lo  ((state == ST_REC_WAIT) && tick && phase),
        .load_byte(state == ST_RD_CAP),
        .code_in  (enc_code),
        .byte_in  (sram_din),
        .byte_q   (byte_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (rec_btn)       state_nx = ST_REC_WAIT;
                else if (play_btn) state_nx = ST_PLAY_WAIT;
            end
            ST_REC_WAIT:  if (tick && phase) state_nx = ST_WR_ADDR;
            ST_WR_ADDR:   state_nx = ST_WR_OEH;
            ST_WR_OEH:    state_nx = ST_WR_WEL;
            ST_WR_WEL:    state_nx = ST_WR_DATA;
            ST_WR_DATA:   state_nx = ST_WR_REL;
            ST_WR_REL:    state_nx = last ? ST_IDLE : ST_REC_WAIT;
            ST_PLAY_WAIT: begin
                if (tick && !phase)    state_nx = ST_RD_ADDR;
                else if (play_lo_tick && last) state_nx = ST_IDLE;
            end
            ST_RD_ADDR:   state_nx = ST_RD_OEL;
            ST_RD_OEL:    state_nx = ST_RD_CAP;
            ST_RD_CAP:    state_nx = ST_PLAY_WAIT;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        sram_we_n  = 1'b1;
        sram_oe_n  = 1'b1;
        sram_dq_oe = 1'b0;
        seq_run    = 1'b0;
        mode       = MODE_IDLE;
        unique case (state)
            ST_IDLE:      mode = MODE_IDLE;
            ST_REC_WAIT:  mode = MODE_REC;
            ST_WR_ADDR, ST_WR_OEH: begin
                mode = MODE_REC; seq_run = 1'b1;
            end
            ST_WR_WEL: begin
                mode = MODE_REC; seq_run = 1'b1; sram_we_n = 1'b0;
            end
            ST_WR_DATA: begin
                mode = MODE_REC; seq_run = 1'b1; sram_we_n = 1'b0; sram_dq_oe = 1'b1;
            end
            ST_WR_REL: begin
                mode = MODE_REC; seq_run = 1'b1; sram_dq_oe = 1'b1;
            end
            ST_PLAY_WAIT: mode = MODE_PLAY;
            ST_RD_ADDR: begin
                mode = MODE_PLAY; seq_run = 1'b1;
            end
            ST_RD_OEL, ST_RD_CAP: begin
                mode = MODE_PLAY; seq_run = 1'b1; sram_oe_n = 1'b0;
            end
            default:      mode = MODE_IDLE;
        endcase
    end

    assign busy      = (mode != MODE_IDLE);
    assign sram_dout = byte_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= 1'b0;
            pwm_duty  <= '0;
            dec_code  <= '0;
            dec_valid <= 1'b0;
            err       <= 1'b0;
        end else begin
            dec_valid <= 1'b0;
            if (tick && seq_run) err <= 1'b1;
            if (enter) begin
                phase    <= 1'b0;
                pwm_duty <= '0;
            end
            if (state == ST_REC_WAIT && tick) phase <= ~phase;
            if (state == ST_WR_REL && last) pwm_duty <= '0;
            if (state == ST_PLAY_WAIT && tick) begin
                pwm_duty <= (phase && last) ? '0 : dec_sample;
            end
            if (state == ST_RD_CAP) begin
                dec_code  <= sram_din[DATA_W-1 -: CODE_W];
                dec_valid <= 1'b1;
                phase     <= 1'b1;
            end
            if (play_lo_tick) begin
                dec_code  <= byte_q[CODE_W-1:0];
                dec_valid <= 1'b1;
                phase     <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vs_seq_chk.sv
module vs_seq_chk #(
    parameter int PWM_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sram_we_n,
    input logic             sram_oe_n,
    input logic             sram_dq_oe,
    input logic             dec_valid,
    input logic [PWM_W-1:0] pwm_duty,
    input logic [1:0]       mode,
    input logic             busy,
    input logic             err
);
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    p_drive_rec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (mode == 2'd1));

    p_we_after_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> (sram_oe_n && $past(sram_oe_n)));

    p_release_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe);

    p_oe_play_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (mode == 2'd2));

    p_valid_play_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ((mode == 2'd2) || $fell(busy)));

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode));

    p_end_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (pwm_duty == '0));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind voice_seq vs_seq_chk #(.PWM_W(PWM_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n),
    .sram_dq_oe(sram_dq_oe),
    .dec_valid (dec_valid),
    .pwm_duty  (pwm_duty),
    .mode      (mode),
    .busy      (busy),
    .err       (err)
);

// File: tb/test_voice_seq.sv
module test_voice_seq;
    localparam int CW  = 4;
    localparam int AW  = 4;
    localparam int LEN = 3;
    localparam int PW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rec_btn = 1'b0;
    logic          play_btn = 1'b0;
    logic          tick = 1'b0;
    logic [CW-1:0] enc_code = '0;
    logic [7:0]    sram_din;
    logic [PW-1:0] dec_sample;
    logic [AW-1:0] sram_addr;
    logic [7:0]    sram_dout;
    logic          sram_dq_oe, sram_we_n, sram_oe_n;
    logic [CW-1:0] dec_code;
    logic          dec_valid;
    logic [PW-1:0] pwm_duty;
    logic [1:0]    mode;
    logic          busy, err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [7:0] mem [0:15];

    always #10 clk = ~clk;

    voice_seq #(.CODE_W(CW), .ADDR_W(AW), .LEN_BYTES(LEN), .PWM_W(PW)) i_voice_seq (
        .clk(clk), .rst_n(rst_n), .rec_btn(rec_btn), .play_btn(play_btn),
        .tick(tick), .enc_code(enc_code), .sram_din(sram_din),
        .dec_sample(dec_sample), .sram_addr(sram_addr), .sram_dout(sram_dout),
        .sram_dq_oe(sram_dq_oe), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .dec_code(dec_code), .dec_valid(dec_valid), .pwm_duty(pwm_duty),
        .mode(mode), .busy(busy), .err(err)
    );

    // SRAM model and decoder stand-in
    always @(posedge clk) if (!sram_we_n && sram_dq_oe) mem[sram_addr] <= sram_dout;
    assign sram_din   = mem[sram_addr];
    assign dec_sample = {dec_code, 4'h5};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick(input logic [CW-1:0] c);
        @(negedge clk); enc_code = c; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic press(input logic r, input logic p);
        @(negedge clk); rec_btn = r; play_btn = p;
        @(negedge clk); rec_btn = 1'b0; play_btn = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; step(3); rst_n = 1'b1; step(1);
        chk("R1 reset mode", 32'(mode), 0);
        chk("R1 reset busy", 32'(busy), 0);
        chk("R9 reset err", 32'(err), 0);
        chk("R10 reset strobes", {30'd0, sram_we_n, sram_oe_n}, 3);
        chk("R4 reset drive", 32'(sram_dq_oe), 0);
        chk("R8 reset pwm", 32'(pwm_duty), 0);
    endtask

    task automatic t_record;
        logic [CW-1:0] codes [0:5];
        codes = '{4'h3, 4'hA, 4'h5, 4'hC, 4'hF, 4'h0};
        press(1'b1, 1'b0);
        chk("R1 record entry", 32'(mode), 1);
        chk("R6 record start addr", 32'(sram_addr), 0);
        for (int b = 0; b < LEN; b++) begin
            pulse_tick(codes[2*b]);
            step(3);
            chk("R3 no write after first nibble", 32'(sram_dq_oe), 0);
            chk("R3 no write strobe after first nibble", 32'(sram_we_n), 1);
            step(4);
            pulse_tick(codes[2*b+1]);
            chk("R6 write addr", 32'(sram_addr), 32'(b));
            chk("R4 step1", {29'd0, sram_we_n, sram_oe_n, sram_dq_oe}, 32'b110);
            if (b == 0) press(1'b0, 1'b1); else step(2);
            // press occupies two negedges: now in WR_WEL
            chk("R4 step3 WE low", {29'd0, sram_we_n, sram_oe_n, sram_dq_oe}, 32'b010);
            chk("R2 mode held", 32'(mode), 1);
            step(1);
            chk("R4 step4 data", {29'd0, sram_we_n, sram_oe_n, sram_dq_oe}, 32'b011);
            chk("R3 byte packing", 32'(sram_dout), 32'({codes[2*b], codes[2*b+1]}));
            step(1);
            chk("R4 step5 release", {29'd0, sram_we_n, sram_oe_n, sram_dq_oe}, 32'b111);
            step(1);
            chk("R4 bus released", 32'(sram_dq_oe), 0);
            if (b < LEN - 1) chk("R6 addr advance", 32'(sram_addr), 32'(b + 1));
            step(3);
        end
        chk("R7 record end mode", 32'(mode), 0);
        chk("R7 record end pwm", 32'(pwm_duty), 0);
        chk("R3 mem0", 32'(mem[0]), 32'h3A);
        chk("R3 mem1", 32'(mem[1]), 32'h5C);
        chk("R3 mem2", 32'(mem[2]), 32'hF0);
        chk("R9 no err", 32'(err), 0);
    endtask

    task automatic t_play;
        logic [7:0] bytes [0:2];
        bytes = '{8'h3A, 8'h5C, 8'hF0};
        press(1'b0, 1'b1);
        chk("R1 play entry", 32'(mode), 2);
        chk("R6 play start addr", 32'(sram_addr), 0);
        for (int b = 0; b < LEN; b++) begin
            logic [PW-1:0] prev;
            prev = dec_sample;
            pulse_tick(4'h0);
            chk("R8 pwm on fetch tick", 32'(pwm_duty), 32'(prev));
            chk("R5 read addr step", {30'd0, sram_oe_n, sram_we_n}, 3);
            chk("R6 read addr", 32'(sram_addr), 32'(b));
            if (b == 1) press(1'b1, 1'b0); else step(2);
            chk("R5 OE low", 32'(sram_oe_n), 0);
            chk("R2 mode held", 32'(mode), 2);
            step(1);
            chk("R5 high nibble valid", 32'(dec_valid), 1);
            chk("R5 high nibble", 32'(dec_code), 32'(bytes[b][7:4]));
            chk("R5 OE released", 32'(sram_oe_n), 1);
            step(1);
            chk("R5 valid single", 32'(dec_valid), 0);
            step(4);
            prev = dec_sample;
            pulse_tick(4'h0);
            chk("R5 low nibble valid", 32'(dec_valid), 1);
            chk("R5 low nibble", 32'(dec_code), 32'(bytes[b][3:0]));
            if (b < LEN - 1) begin
                chk("R8 pwm on low tick", 32'(pwm_duty), 32'(prev));
                chk("R6 play addr advance", 32'(sram_addr), 32'(b + 1));
            end
            step(5);
        end
        chk("R7 play end mode", 32'(mode), 0);
        chk("R7 play end pwm", 32'(pwm_duty), 0);
    endtask

    task automatic t_fault;
        press(1'b1, 1'b1);
        chk("R1 record wins", 32'(mode), 1);
        pulse_tick(4'h1);
        step(4);
        pulse_tick(4'h2);
        pulse_tick(4'h3);
        chk("R9 late tick sets err", 32'(err), 1);
        step(10);
        for (int i = 0; i < 20 && busy; i++) begin
            pulse_tick(4'h4);
            step(8);
        end
        chk("R7 fault run ends", 32'(mode), 0);
        chk("R9 err sticky", 32'(err), 1);
        press(1'b0, 1'b1);
        chk("R9 err sticky in play", 32'(err), 1);
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
        chk("R9 reset clears err", 32'(err), 0);
        chk("R1 reset to standby", 32'(mode), 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        t_reset();
        t_record();
        t_play();
        t_fault();
        summary();
        $finish;
    end
endmodule